// File: doc/BRIEF.md
# Working Register File with Pointer Pairs

This block holds the thirty-two 8-bit working registers of a small processor core. Within one clock cycle the execute stage can fetch two byte operands, or one 16-bit operand made of two adjacent registers. In the same cycle it can write back either a byte result or a 16-bit result. All reads are combinational. Every write lands at the next rising clock edge, so an operand fetch, the arithmetic on it and the write-back all fit in a single cycle.

The six highest registers also serve as three 16-bit address pointers. These are X (R27:R26), Y (R29:R28) and Z (R31:R30), each with its low byte in the even register. The three pointers are always visible as outputs. A dedicated update port writes a whole pointer back, for example after an address post-increment or pre-decrement. The same registers also appear as a byte-wide memory-mapped window at data addresses 0 to 31, so ordinary load and store traffic can reach them. When two writers target the same register in one cycle, the core wins over the pointer port, and the pointer port wins over the memory window.

Top module: `work_regfile`

## Requirements
- R1: While reset is asserted and after it is released, every register reads zero, and all three pointer outputs are zero.
- R2: With wr_en=1 and wr_wide=0, the low byte of wr_data is written to register wr_idx at the next rising edge. Ports A and B show any register combinationally. A read in the same cycle as a write to that register shows the old value.
- R3: With wr_en=1 and wr_wide=1, wr_data[7:0] goes to the even register wr_idx with bit 0 cleared, and wr_data[15:8] goes to the odd register above it. Bit 0 of wr_idx is ignored.
- R4: rd_w_data equals {reg[base+1], reg[base]}, where base is rd_w_idx with bit 0 cleared.
- R5: x_ptr={R27,R26}, y_ptr={R29,R28} and z_ptr={R31,R30} at all times.
- R6: With ptr_we=1, ptr_sel 0, 1 and 2 write ptr_data to X, Y and Z respectively (low byte to the even register). ptr_sel=3 changes nothing.
- R7: With mm_en=1 and mm_addr<32, mm_hit=1 and mm_rdata equals register mm_addr. Otherwise mm_hit=0 and mm_rdata=0.
- R8: With mm_en=1, mm_we=1 and mm_addr<32, mm_wdata is written to register mm_addr. Addresses of 32 and above change no register.
- R9: Per register, a core write beats a pointer write, which beats a memory-window write. Bytes not claimed by a higher-priority writer still take the lower-priority data in that cycle.
- R10: A register that no writer targets in a cycle keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_idx | input | 5 | Byte read port A index |
| rd_a_data | output | 8 | Byte read port A data |
| rd_b_idx | input | 5 | Byte read port B index |
| rd_b_data | output | 8 | Byte read port B data |
| rd_w_idx | input | 5 | 16-bit read base index (bit 0 ignored) |
| rd_w_data | output | 16 | 16-bit read data, high byte from odd register |
| wr_en | input | 1 | Core write enable |
| wr_wide | input | 1 | 1: 16-bit write, 0: byte write |
| wr_idx | input | 5 | Core write index |
| wr_data | input | 16 | Core write data (low byte only for byte writes) |
| ptr_we | input | 1 | Pointer update enable |
| ptr_sel | input | 2 | 0 X, 1 Y, 2 Z, 3 none |
| ptr_data | input | 16 | New pointer value |
| x_ptr | output | 16 | Pointer X |
| y_ptr | output | 16 | Pointer Y |
| z_ptr | output | 16 | Pointer Z |
| mm_en | input | 1 | Memory-window access strobe |
| mm_we | input | 1 | Memory-window write |
| mm_addr | input | 16 | Data address |
| mm_wdata | input | 8 | Memory-window write data |
| mm_rdata | output | 8 | Memory-window read data |
| mm_hit | output | 1 | Address falls in the register window |

## Verification
A fault in the write-select logic has two visible effects. The targeted register keeps stale data, and some other register changes value. Both show up on any read port in the very next cycle, because reads are combinational. A wrong pointer or window mapping appears immediately on x_ptr, y_ptr, z_ptr or mm_rdata, with no added latency. For that reason the sweeps compare the whole register file against the model after each stimulus group, rather than checking only the register just written.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
  // Pointer selector encoding used by the pointer update port.
  typedef enum logic [1:0] {
    PSEL_X    = 2'd0,
    PSEL_Y    = 2'd1,
    PSEL_Z    = 2'd2,
    PSEL_NONE = 2'd3
  } ptr_sel_e;

  // True when a core write at index idx (byte or pair) covers register reg_i.
  function automatic bit core_targets(int reg_i, int idx, bit wide);
    return wide ? ((reg_i >> 1) == (idx >> 1)) : (reg_i == idx);
  endfunction

  // True when pointer number sel (0..2) covers register reg_i.
  function automatic bit ptr_targets(int reg_i, int ptr_base, int sel);
    if (reg_i < ptr_base || reg_i >= ptr_base + 6) return 1'b0;
    return ((reg_i - ptr_base) >> 1) == sel;
  endfunction
endpackage

// File: rtl/wrf_read_mux.sv
module wrf_read_mux #(
  parameter int NREG = 32,
  parameter int DW   = 8,
  localparam int AW  = $clog2(NREG)
) (
  input  logic [NREG*DW-1:0] rf_flat,
  input  logic [AW-1:0]      idx,
  output logic [DW-1:0]      data
);
  assign data = rf_flat[idx*DW +: DW];
endmodule

// File: rtl/wrf_mmio.sv
module wrf_mmio #(
  parameter int NREG = 32,
  parameter int DW   = 8,
  parameter int MAW  = 16,
  localparam int AW  = $clog2(NREG)
) (
  input  logic [NREG*DW-1:0] rf_flat,
  input  logic               mm_en,
  input  logic               mm_we,
  input  logic [MAW-1:0]     mm_addr,
  output logic               mm_hit,
  output logic               mm_wr,
  output logic [AW-1:0]      mm_idx,
  output logic [DW-1:0]      mm_rdata
);
  assign mm_hit   = mm_en && (mm_addr < MAW'(NREG));
  assign mm_idx   = mm_addr[AW-1:0];
  assign mm_wr    = mm_hit && mm_we;
  assign mm_rdata = mm_hit ? rf_flat[mm_idx*DW +: DW] : '0;
endmodule

// File: rtl/wrf_write_arb.sv
module wrf_write_arb
  import wrf_pkg::*;
#(
  parameter int NREG     = 32,
  parameter int DW       = 8,
  parameter int PTR_BASE = 26,
  localparam int AW      = $clog2(NREG)
) (
  input  logic               wr_en,
  input  logic               wr_wide,
  input  logic [AW-1:0]      wr_idx,
  input  logic [2*DW-1:0]    wr_data,
  input  logic               ptr_we,
  input  logic [1:0]         ptr_sel,
  input  logic [2*DW-1:0]    ptr_data,
  input  logic               mm_wr,
  input  logic [AW-1:0]      mm_idx,
  input  logic [DW-1:0]      mm_wdata,
  output logic [NREG-1:0]    core_mask,
  output logic [NREG-1:0]    ptr_mask,
  output logic [NREG-1:0]    mm_mask,
  output logic [NREG-1:0]    we_vec,
  output logic [NREG*DW-1:0] wd_flat
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam bit ODD = (i % 2) == 1;
    logic [DW-1:0] core_byte, ptr_byte;
    assign core_mask[i] = wr_en && core_targets(i, int'(wr_idx), wr_wide);
    assign ptr_mask[i]  = ptr_we && ptr_targets(i, PTR_BASE, int'(ptr_sel));
    assign mm_mask[i]   = mm_wr && (int'(mm_idx) == i);
    assign core_byte    = (wr_wide && ODD) ? wr_data[2*DW-1:DW] : wr_data[DW-1:0];
    assign ptr_byte     = ODD ? ptr_data[2*DW-1:DW] : ptr_data[DW-1:0];
    assign we_vec[i]    = core_mask[i] | ptr_mask[i] | mm_mask[i];
    assign wd_flat[i*DW +: DW] = core_mask[i] ? core_byte :
                                 ptr_mask[i]  ? ptr_byte  : mm_wdata;
  end
endmodule

// File: rtl/work_regfile.sv
module work_regfile #(
  parameter int NREG     = 32,
  parameter int DW       = 8,
  parameter int PTR_BASE = 26,
  parameter int MAW      = 16,
  localparam int AW      = $clog2(NREG),
  localparam int PW      = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_a_idx,
  output logic [DW-1:0] rd_a_data,
  input  logic [AW-1:0] rd_b_idx,
  output logic [DW-1:0] rd_b_data,
  input  logic [AW-1:0] rd_w_idx,
  output logic [PW-1:0] rd_w_data,
  input  logic          wr_en,
  input  logic          wr_wide,
  input  logic [AW-1:0] wr_idx,
  input  logic [PW-1:0] wr_data,
  input  logic          ptr_we,
  input  logic [1:0]    ptr_sel,
  input  logic [PW-1:0] ptr_data,
  output logic [PW-1:0] x_ptr,
  output logic [PW-1:0] y_ptr,
  output logic [PW-1:0] z_ptr,
  input  logic          mm_en,
  input  logic          mm_we,
  input  logic [MAW-1:0] mm_addr,
  input  logic [DW-1:0] mm_wdata,
  output logic [DW-1:0] mm_rdata,
  output logic          mm_hit
);
  logic [DW-1:0]      rf_q [NREG];
  logic [NREG*DW-1:0] rf_flat;
  logic [NREG-1:0]    core_mask, ptr_mask, mm_mask, we_vec;
  logic [NREG*DW-1:0] wd_flat;
  logic               mm_wr;
  logic [AW-1:0]      mm_idx;
  logic [AW-1:0]      pair_lo_idx, pair_hi_idx;
  logic [3*PW-1:0]    ptr_flat;

  // Storage: one register per entry, written from the arbitrated vectors.
  for (genvar i = 0; i < NREG; i++) begin : g_store
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         rf_q[i] <= '0;
      else if (we_vec[i]) rf_q[i] <= wd_flat[i*DW +: DW];
    end
    assign rf_flat[i*DW +: DW] = rf_q[i];
  end

  wrf_write_arb #(.NREG(NREG), .DW(DW), .PTR_BASE(PTR_BASE)) arb_i (
    .wr_en(wr_en), .wr_wide(wr_wide), .wr_idx(wr_idx), .wr_data(wr_data),
    .ptr_we(ptr_we), .ptr_sel(ptr_sel), .ptr_data(ptr_data),
    .mm_wr(mm_wr), .mm_idx(mm_idx), .mm_wdata(mm_wdata),
    .core_mask(core_mask), .ptr_mask(ptr_mask), .mm_mask(mm_mask),
    .we_vec(we_vec), .wd_flat(wd_flat)
  );

  wrf_mmio #(.NREG(NREG), .DW(DW), .MAW(MAW)) mmio_i (
    .rf_flat(rf_flat), .mm_en(mm_en), .mm_we(mm_we), .mm_addr(mm_addr),
    .mm_hit(mm_hit), .mm_wr(mm_wr), .mm_idx(mm_idx), .mm_rdata(mm_rdata)
  );

  wrf_read_mux #(.NREG(NREG), .DW(DW)) rd_a_i (.rf_flat(rf_flat), .idx(rd_a_idx), .data(rd_a_data));
  wrf_read_mux #(.NREG(NREG), .DW(DW)) rd_b_i (.rf_flat(rf_flat), .idx(rd_b_idx), .data(rd_b_data));

  assign pair_lo_idx = {rd_w_idx[AW-1:1], 1'b0};
  assign pair_hi_idx = {rd_w_idx[AW-1:1], 1'b1};
  wrf_read_mux #(.NREG(NREG), .DW(DW)) rd_wl_i (.rf_flat(rf_flat), .idx(pair_lo_idx), .data(rd_w_data[DW-1:0]));
  wrf_read_mux #(.NREG(NREG), .DW(DW)) rd_wh_i (.rf_flat(rf_flat), .idx(pair_hi_idx), .data(rd_w_data[PW-1:DW]));

  // Pointer aliases over the top register pairs.
  for (genvar p = 0; p < 3; p++) begin : g_ptr
    assign ptr_flat[p*PW +: PW] = {rf_q[PTR_BASE + 2*p + 1], rf_q[PTR_BASE + 2*p]};
  end
  assign x_ptr = ptr_flat[0*PW +: PW];
  assign y_ptr = ptr_flat[1*PW +: PW];
  assign z_ptr = ptr_flat[2*PW +: PW];
endmodule

// File: rtl/wrf_checker.sv
module wrf_checker #(
  parameter int NREG = 32,
  parameter int DW   = 8,
  localparam int AW  = $clog2(NREG),
  localparam int PW  = 2 * DW
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NREG*DW-1:0] rf_flat,
  input logic [NREG-1:0]    core_mask,
  input logic [NREG-1:0]    ptr_mask,
  input logic [NREG-1:0]    mm_mask,
  input logic               wr_en,
  input logic               wr_wide,
  input logic [AW-1:0]      wr_idx,
  input logic [PW-1:0]      wr_data,
  input logic               ptr_we,
  input logic [1:0]         ptr_sel,
  input logic [PW-1:0]      ptr_data,
  input logic [PW-1:0]      x_ptr,
  input logic [PW-1:0]      y_ptr,
  input logic [PW-1:0]      z_ptr,
  input logic               mm_wr,
  input logic [AW-1:0]      mm_idx,
  input logic [DW-1:0]      mm_wdata,
  input logic               mm_hit,
  input logic [DW-1:0]      mm_rdata
);
  logic [AW-1:0] wide_lo;
  logic [PW-1:0] ptr_view;
  logic [1:0]    psel_q;
  assign wide_lo = {wr_idx[AW-1:1], 1'b0};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) psel_q <= '0;
    else        psel_q <= ptr_sel;
  assign ptr_view = (psel_q == 2'd0) ? x_ptr : (psel_q == 2'd1) ? y_ptr : z_ptr;

  AST_BYTE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_wide) |=> rf_flat[$past(wr_idx)*DW +: DW] == $past(wr_data[DW-1:0])); // R2
  AST_PAIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_wide) |=> (rf_flat[$past(wide_lo)*DW +: DW] == $past(wr_data[DW-1:0]))
                        && (rf_flat[($past(wide_lo)+1)*DW +: DW] == $past(wr_data[PW-1:DW]))); // R3
  AST_PTR_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_we && ptr_sel != 2'd3 && !(|(core_mask & ptr_mask))) |=> ptr_view == $past(ptr_data)); // R6
  AST_MM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_wr && !core_mask[mm_idx] && !ptr_mask[mm_idx]) |=> rf_flat[$past(mm_idx)*DW +: DW] == $past(mm_wdata)); // R8
  AST_MM_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mm_hit |-> mm_rdata == rf_flat[mm_idx*DW +: DW]); // R7
  AST_MM_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mm_mask)); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(core_mask | ptr_mask | mm_mask)) |=> $stable(rf_flat)); // R10
endmodule

bind work_regfile wrf_checker #(.NREG(NREG), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .rf_flat(rf_flat),
  .core_mask(core_mask), .ptr_mask(ptr_mask), .mm_mask(mm_mask),
  .wr_en(wr_en), .wr_wide(wr_wide), .wr_idx(wr_idx), .wr_data(wr_data),
  .ptr_we(ptr_we), .ptr_sel(ptr_sel), .ptr_data(ptr_data),
  .x_ptr(x_ptr), .y_ptr(y_ptr), .z_ptr(z_ptr),
  .mm_wr(mm_wr), .mm_idx(mm_idx), .mm_wdata(mm_wdata),
  .mm_hit(mm_hit), .mm_rdata(mm_rdata)
);

// File: tb/work_regfile_tb_top.sv
module work_regfile_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] rd_a_idx = '0, rd_b_idx = '0, rd_w_idx = '0, wr_idx = '0;
  logic [7:0] rd_a_data, rd_b_data, mm_wdata = '0, mm_rdata;
  logic [15:0] rd_w_data, wr_data = '0, ptr_data = '0, x_ptr, y_ptr, z_ptr, mm_addr = '0;
  logic wr_en = 0, wr_wide = 0, ptr_we = 0, mm_en = 0, mm_we = 0, mm_hit;
  logic [1:0] ptr_sel = '0;
  logic [7:0] exp_rf [32];
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  work_regfile dut_i (.*);

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
    wr_en = 0; wr_wide = 0; ptr_we = 0; mm_en = 0; mm_we = 0;
  endtask

  task automatic check_all(string req);
    for (int i = 0; i < 32; i++) begin
      rd_a_idx = 5'(i); rd_b_idx = 5'(31 - i); #1;
      chk(rd_a_data == exp_rf[i], req, rd_a_data, exp_rf[i]);
      chk(rd_b_data == exp_rf[31-i], req, rd_b_data, exp_rf[31-i]);
    end
    chk(x_ptr == {exp_rf[27], exp_rf[26]}, {req, " R5 X"}, x_ptr, {exp_rf[27], exp_rf[26]});
    chk(y_ptr == {exp_rf[29], exp_rf[28]}, {req, " R5 Y"}, y_ptr, {exp_rf[29], exp_rf[28]});
    chk(z_ptr == {exp_rf[31], exp_rf[30]}, {req, " R5 Z"}, z_ptr, {exp_rf[31], exp_rf[30]});
  endtask

  initial begin
    for (int i = 0; i < 32; i++) exp_rf[i] = 8'h00;
    #5; check_all("R1 in reset");
    @(negedge clk); @(negedge clk); rst_n = 1; @(negedge clk);
    check_all("R1 after reset");

    // R2: byte writes, old value visible in the write cycle
    for (int i = 0; i < 32; i++) begin
      wr_en = 1; wr_idx = 5'(i); wr_data = {8'hEE, 8'((i * 37 + 11) & 255)};
      rd_a_idx = 5'(i); #1;
      chk(rd_a_data == exp_rf[i], "R2 old value", rd_a_data, exp_rf[i]);
      exp_rf[i] = 8'((i * 37 + 11) & 255);
      step();
    end
    check_all("R2");

    // R3/R4: pair writes, odd index bit ignored on write and read
    for (int p = 0; p < 16; p++) begin
      logic [15:0] v = 16'(p * 16'h1111) ^ 16'hA5C3;
      wr_en = 1; wr_wide = 1; wr_idx = 5'(2 * p + (p % 2)); wr_data = v;
      exp_rf[2*p] = v[7:0]; exp_rf[2*p+1] = v[15:8];
      step();
    end
    for (int p = 0; p < 16; p++) begin
      rd_w_idx = 5'(2 * p + ((p + 1) % 2)); #1;
      chk(rd_w_data == {exp_rf[2*p+1], exp_rf[2*p]}, "R4", rd_w_data, {exp_rf[2*p+1], exp_rf[2*p]});
    end
    check_all("R3");

    // R6: pointer updates, selector 3 ignored
    for (int s = 0; s < 4; s++) begin
      ptr_we = 1; ptr_sel = 2'(s); ptr_data = 16'h3C00 + 16'(s * 16'h0105);
      if (s < 3) begin
        exp_rf[26 + 2*s] = ptr_data[7:0]; exp_rf[27 + 2*s] = ptr_data[15:8];
      end
      step();
      check_all(s < 3 ? "R6" : "R6 sel3 ignored");
    end

    // R7: window reads over every register and outside it
    for (int a = 0; a < 32; a++) begin
      mm_en = 1; mm_addr = 16'(a); #1;
      chk(mm_hit == 1'b1, "R7 hit", mm_hit, 1);
      chk(mm_rdata == exp_rf[a], "R7 data", mm_rdata, exp_rf[a]);
    end
    mm_addr = 16'd32; #1;
    chk(mm_hit == 0 && mm_rdata == 0, "R7 addr 32", {mm_hit, mm_rdata}, 0);
    mm_addr = 16'hFFFF; #1;
    chk(mm_hit == 0 && mm_rdata == 0, "R7 addr FFFF", {mm_hit, mm_rdata}, 0);
    mm_en = 0; mm_addr = 16'd3; #1;
    chk(mm_hit == 0 && mm_rdata == 0, "R7 strobe low", {mm_hit, mm_rdata}, 0);

    // R8: window writes in and out of range
    for (int a = 0; a < 32; a++) begin
      mm_en = 1; mm_we = 1; mm_addr = 16'(a); mm_wdata = 8'(255 - a * 5);
      exp_rf[a] = 8'(255 - a * 5);
      step();
    end
    check_all("R8");
    mm_en = 1; mm_we = 1; mm_addr = 16'd40; mm_wdata = 8'h77; step();
    mm_en = 1; mm_we = 1; mm_addr = 16'h1000; mm_wdata = 8'h66; step();
    check_all("R8 out of range R10");

    // R9: collisions
    wr_en = 1; wr_idx = 5'd5; wr_data = 16'h0091; mm_en = 1; mm_we = 1; mm_addr = 16'd5; mm_wdata = 8'h22;
    exp_rf[5] = 8'h91; step(); check_all("R9 core over window");
    wr_en = 1; wr_wide = 1; wr_idx = 5'd26; wr_data = 16'hB4A3;
    ptr_we = 1; ptr_sel = 2'd1; ptr_data = 16'hD2C1;
    mm_en = 1; mm_we = 1; mm_addr = 16'd28; mm_wdata = 8'h55;
    exp_rf[26] = 8'hA3; exp_rf[27] = 8'hB4; exp_rf[28] = 8'hC1; exp_rf[29] = 8'hD2;
    step(); check_all("R9 disjoint writers");
    wr_en = 1; wr_idx = 5'd27; wr_data = 16'h00E7; ptr_we = 1; ptr_sel = 2'd0; ptr_data = 16'h1F2E;
    exp_rf[26] = 8'h2E; exp_rf[27] = 8'hE7; step(); check_all("R9 core over pointer");
    ptr_we = 1; ptr_sel = 2'd2; ptr_data = 16'h4B5A; mm_en = 1; mm_we = 1; mm_addr = 16'd30; mm_wdata = 8'h01;
    exp_rf[30] = 8'h5A; exp_rf[31] = 8'h4B; step(); check_all("R9 pointer over window");
    ptr_we = 1; ptr_sel = 2'd0; ptr_data = 16'h6978; mm_en = 1; mm_we = 1; mm_addr = 16'd31; mm_wdata = 8'h8C;
    exp_rf[26] = 8'h78; exp_rf[27] = 8'h69; exp_rf[31] = 8'h8C; step(); check_all("R9 window lands beside pointer");

    // R1: reset again clears everything
    rst_n = 0; #1;
    for (int i = 0; i < 32; i++) exp_rf[i] = 8'h00;
    check_all("R1 reassert");
    @(negedge clk); rst_n = 1;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule